// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves data between two 18-bit ports, A and B, with an independent path in each direction. Each path has one storage element. A latch-enable input puts that element in one of two modes. With the enable high, the element is transparent and tracks the source port. With the enable low, the element is an edge-triggered register that loads only on a rising edge of that path's own transfer clock. Each output has a drive enable that stands in for a tri-state buffer. The A-to-B path enables its output with an active-high control. The B-to-A path uses an active-low control.

The whole block runs on one system clock. The two transfer clocks are sampled as ordinary inputs, and their rising edges are found by comparing each sample with the previous one. Each input bit has its own "driven" flag. While a bit's flag is low, a keeper register supplies the last value that bit carried while driven. An undriven bus therefore never feeds an unknown value into the storage.

Top module: `bus_xcvr_latreg`

## Requirements
- R1: With `ab_le` = 1 at a system clock edge, `b_data` after that edge equals the effective A value at that edge. The effective value of each bit is `a_in` where `a_in_vld` is 1, and the kept value where it is 0.
- R2: With `ab_le` = 0 and no rising transition of `ab_clk`, `b_data` does not change. This covers `ab_clk` held at either level.
- R3: With `ab_le` = 0, a rising transition of `ab_clk` loads the effective A value at the edge where `ab_clk` is first seen high (`ab_clk` = 1 now and 0 at the previous edge). A falling transition loads nothing.
- R4: `b_drv` after a clock edge equals `ab_oe` at that edge, so the control is active high. `b_data` shows the stored value whatever the state of `b_drv`.
- R5: The B-to-A path follows R1 to R3 using `ba_le`, `ba_clk`, `b_in` and `b_in_vld`, and its stored value appears on `a_data`.
- R6: `a_drv` after a clock edge equals the inverse of `ba_oe_n` at that edge, so the control is active low.
- R7: Each input bit has a keeper. The keeper loads the input bit while that bit's valid flag is 1 and holds its value while the flag is 0. A released bit therefore passes on its last driven value.
- R8: While `rst_n` = 0, both storage elements, both keepers and both transfer-clock history bits are 0, and `b_drv` and `a_drv` are 0.
- R9: Both directions may be enabled together. Each then carries its own source value with no effect on the other direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| a_in | input | 18 | A-side input data |
| a_in_vld | input | 18 | Per-bit "driven" flags for A |
| b_in | input | 18 | B-side input data |
| b_in_vld | input | 18 | Per-bit "driven" flags for B |
| ab_le | input | 1 | A-to-B latch enable (1 = transparent) |
| ab_clk | input | 1 | A-to-B transfer clock (sampled) |
| ab_oe | input | 1 | A-to-B output enable, active high |
| ba_le | input | 1 | B-to-A latch enable (1 = transparent) |
| ba_clk | input | 1 | B-to-A transfer clock (sampled) |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| b_data | output | 18 | Stored A-to-B value driven toward B |
| b_drv | output | 1 | B-side drive enable (0 = high impedance) |
| a_data | output | 18 | Stored B-to-A value driven toward A |
| a_drv | output | 1 | A-side drive enable (0 = high impedance) |

## Verification
The bench targets several specific mistakes:
- A rising-edge detector that also fires on the falling transition. It would load new data when the transfer clock goes low.
- Swapped enable polarities. These would drive B when `ab_oe` is low, or drive A when `ba_oe_n` is high.
- A keeper that loads while its flag is low. It would leak the floating value of a released bus into the path.
- A cross-coupled path. It would let one direction's data or mode leak into the other when both are enabled.

Seeded random traffic mixes modes, partial valid masks and clock toggles. Directed sequences isolate each of these cases.

// File: rtl/bus_xcvr_latreg.sv
module bus_xcvr_latreg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] a_in_vld,
  input  logic [W-1:0] b_in,
  input  logic [W-1:0] b_in_vld,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_oe,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_oe_n,
  output logic [W-1:0] b_data,
  output logic         b_drv,
  output logic [W-1:0] a_data,
  output logic         a_drv
);

  logic [W-1:0] a_keep, b_keep;
  logic [W-1:0] a_eff, b_eff;
  logic [W-1:0] ab_q, ba_q;
  logic         ab_clk_q, ba_clk_q;
  logic         ab_rise, ba_rise;

  // per-bit keeper: live bit when driven, held bit otherwise
  assign a_eff = (a_in & a_in_vld) | (a_keep & ~a_in_vld);
  assign b_eff = (b_in & b_in_vld) | (b_keep & ~b_in_vld);

  assign ab_rise = ab_clk & ~ab_clk_q;
  assign ba_rise = ba_clk & ~ba_clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_keep   <= '0;
      b_keep   <= '0;
      ab_clk_q <= 1'b0;
      ba_clk_q <= 1'b0;
    end else begin
      a_keep   <= a_eff;
      b_keep   <= b_eff;
      ab_clk_q <= ab_clk;
      ba_clk_q <= ba_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ab_q  <= '0;
      b_drv <= 1'b0;
    end else begin
      if (ab_le || ab_rise) ab_q <= a_eff;
      b_drv <= ab_oe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q  <= '0;
      a_drv <= 1'b0;
    end else begin
      if (ba_le || ba_rise) ba_q <= b_eff;
      a_drv <= ~ba_oe_n;
    end
  end

  assign b_data = ab_q;
  assign a_data = ba_q;

  AST_AB_TRANSP: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_le && &a_in_vld) |=> b_data == $past(a_in)); // R1
  AST_AB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_clk) |=> $stable(b_data)); // R2
  AST_AB_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && ab_clk && !ab_clk_q && &a_in_vld) |=> b_data == $past(a_in)); // R3
  AST_B_DRV_ON: assert property (@(posedge clk) disable iff (!rst_n)
    ab_oe |=> b_drv); // R4
  AST_B_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ab_oe |=> !b_drv); // R4
  AST_BA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_le && !ba_clk) |=> $stable(a_data)); // R5
  AST_A_DRV_ON: assert property (@(posedge clk) disable iff (!rst_n)
    !ba_oe_n |=> a_drv); // R6
  AST_A_DRV_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ba_oe_n |=> !a_drv); // R6
  AST_A_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (a_in_vld == '0) |=> $stable(a_keep)); // R7
  AST_B_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (b_in_vld == '0) |=> $stable(b_keep)); // R7

  always_comb begin
    if (!rst_n) AST_RST_IDLE: assert (!b_drv && !a_drv); // R8
  end

endmodule

// File: tb/tb_bus_xcvr_latreg.sv
module tb_bus_xcvr_latreg;
  localparam int W = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, a_in_vld = '0, b_in = '0, b_in_vld = '0;
  logic ab_le = 0, ab_clk = 0, ab_oe = 0, ba_le = 0, ba_clk = 0, ba_oe_n = 1;
  logic [W-1:0] b_data, a_data;
  logic b_drv, a_drv;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [W-1:0] m_akeep = '0, m_bkeep = '0, m_abq = '0, m_baq = '0;
  logic m_abclk = 0, m_baclk = 0, m_bdrv = 0, m_adrv = 0;
  string t_ab = "R1", t_ba = "R5";

  always #10 clk = ~clk;

  bus_xcvr_latreg #(.W(W)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_in_vld(a_in_vld), .b_in(b_in), .b_in_vld(b_in_vld),
    .ab_le(ab_le), .ab_clk(ab_clk), .ab_oe(ab_oe),
    .ba_le(ba_le), .ba_clk(ba_clk), .ba_oe_n(ba_oe_n),
    .b_data(b_data), .b_drv(b_drv), .a_data(a_data), .a_drv(a_drv));

  function automatic logic [W-1:0] kept(input logic [W-1:0] d, input logic [W-1:0] v,
                                        input logic [W-1:0] old);
    return (d & v) | (old & ~v);
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic [W-1:0] ae, be;
    ae = kept(a_in, a_in_vld, m_akeep);
    be = kept(b_in, b_in_vld, m_bkeep);
    t_ab = ab_le ? "R1" : (ab_clk && !m_abclk) ? "R3" : "R2";
    t_ba = "R5";
    if (ab_le || (ab_clk && !m_abclk)) m_abq = ae;
    if (ba_le || (ba_clk && !m_baclk)) m_baq = be;
    m_akeep = ae; m_bkeep = be;
    m_abclk = ab_clk; m_baclk = ba_clk;
    m_bdrv = ab_oe; m_adrv = ~ba_oe_n;
  endtask

  task automatic tick();
    model_step();
    @(negedge clk);
    chk(t_ab, b_data, m_abq);
    chk(t_ba, a_data, m_baq);
    chk("R4", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, m_bdrv});
    chk("R6", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, m_adrv});
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] p1, p2;
    void'($urandom(32'd4711));
    // R8: reset state
    a_in = '1; a_in_vld = '1; b_in = '1; b_in_vld = '1;
    ab_le = 1; ba_le = 1; ab_oe = 1; ba_oe_n = 0;
    repeat (3) @(negedge clk);
    chk("R8", b_data, '0); chk("R8", a_data, '0);
    chk("R8", {{(W-1){1'b0}}, b_drv | a_drv}, '0);
    a_in_vld = '0; b_in_vld = '0; ab_le = 0; ba_le = 0; ab_oe = 0; ba_oe_n = 1;
    rst_n = 1;
    tick();

    // R1: transparent A to B
    ab_le = 1; a_in = 18'h2A5C3; a_in_vld = '1; ab_oe = 1; tick();
    chk("R1", b_data, 18'h2A5C3);
    // R2: hold, clock low then high-static
    p1 = 18'h2A5C3;
    ab_le = 0; a_in = 18'h15A3C; tick(); chk("R2", b_data, p1);
    // R3: rising edge captures, falling edge does not
    ab_clk = 1; tick(); chk("R3", b_data, 18'h15A3C);
    a_in = 18'h0F0F0; tick(); chk("R2", b_data, 18'h15A3C);
    ab_clk = 0; tick(); chk("R3", b_data, 18'h15A3C);
    // R4: active-high enable
    ab_oe = 0; tick(); chk("R4", {{(W-1){1'b0}}, b_drv}, '0);
    // R6: active-low enable
    ba_oe_n = 0; tick(); chk("R6", {{(W-1){1'b0}}, a_drv}, 18'h1);
    ba_oe_n = 1; tick(); chk("R6", {{(W-1){1'b0}}, a_drv}, '0);
    // R7: keeper retention after release, full and partial
    ab_le = 1; a_in = 18'h3C3C3; a_in_vld = '1; tick();
    a_in_vld = '0; a_in = 18'h01234; tick(); tick();
    chk("R7", b_data, 18'h3C3C3);
    a_in_vld = 18'h001FF; a_in = 18'h00000; tick();
    chk("R7", b_data, 18'h3C200);
    // R5: B-to-A latch and edge
    ba_le = 1; b_in = 18'h1B2C4; b_in_vld = '1; tick();
    chk("R5", a_data, 18'h1B2C4);
    ba_le = 0; b_in = 18'h22222; tick(); chk("R5", a_data, 18'h1B2C4);
    ba_clk = 1; tick(); chk("R5", a_data, 18'h22222);
    // R9: both directions enabled at once
    p1 = 18'h0AAAA; p2 = 18'h35555;
    ab_le = 1; ba_le = 1; ab_oe = 1; ba_oe_n = 0;
    a_in = p1; a_in_vld = '1; b_in = p2; b_in_vld = '1; tick();
    chk("R9", b_data, p1); chk("R9", a_data, p2);
    chk("R9", {{(W-2){1'b0}}, b_drv, a_drv}, 18'h3);

    // constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      a_in = W'($urandom); b_in = W'($urandom);
      a_in_vld = ($urandom % 3 == 0) ? W'($urandom) : '1;
      b_in_vld = ($urandom % 3 == 0) ? W'($urandom) : '1;
      if ($urandom % 8 == 0) a_in_vld = '0;
      ab_le = ($urandom % 4 == 0); ba_le = ($urandom % 4 == 0);
      ab_clk = $urandom % 2; ba_clk = $urandom % 2;
      ab_oe = $urandom % 2; ba_oe_n = $urandom % 2;
      tick();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule